// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the operation and function fields of a 32-bit instruction word into the control lines that steer a single-cycle datapath. The lines cover the destination register choice, the ALU second operand choice, the write-back source and the register and memory write enables. They also cover the branch and jump selects, the immediate extension mode and a 2-bit ALU operation code. The block is purely combinational, so its outputs follow the instruction in the same cycle.

The decoder is laid out as two explicit planes. An AND plane recognises each of seven instructions as one product term: register add, register subtract, OR-immediate, load word, store word, branch-if-equal and jump. An OR plane then forms each control line as the OR of the terms that need it. Any encoding outside the seven matches no term, so every output goes to 0 and no architectural state can change. Outputs that an instruction does not care about are also held at 0, so every output value is fully defined.

Top module: `sc_ctrl_decode`

## Requirements
- R1: A term matches only on an exact operation field: 000000 (register type, which also needs function field 100000 for add or 100010 for subtract), 001101 OR-immediate, 100011 load, 101011 store, 000100 branch-if-equal, 000010 jump. The function field is ignored for every operation other than 000000.
- R2: `alu_op_o` is 01 (subtract) for subtract and branch-if-equal, 10 (OR) for OR-immediate, and 00 (add) for add, load, store and jump.
- R3: `dst_rd_o` is 1 for add and subtract only.
- R4: `alu_b_imm_o` is 1 for OR-immediate, load and store only.
- R5: `wb_mem_o` is 1 for load only, and `dm_we_o` is 1 for store only.
- R6: `rf_we_o` is 1 for add, subtract, OR-immediate and load only.
- R7: `br_sel_o` is 1 for branch-if-equal only, and `jmp_o` is 1 for jump only.
- R8: `ext_sign_o` is 1 (sign extend) for load and store. It is 0 (zero extend) for OR-immediate.
- R9: An unrecognised operation field, or a register-type word with any other function field, drives every output to 0.
- R10: Every output that an instruction leaves as don't-care is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation field of the instruction (bits 31..26) |
| fn_i | input | 6 | Function field of the instruction (bits 5..0) |
| dst_rd_o | output | 1 | 1: write to the rd register field; 0: write to rt |
| alu_b_imm_o | output | 1 | 1: ALU second operand is the extended immediate |
| wb_mem_o | output | 1 | 1: write-back data comes from data memory |
| rf_we_o | output | 1 | Register file write enable |
| dm_we_o | output | 1 | Data memory write enable |
| br_sel_o | output | 1 | Branch select for the next-PC logic |
| jmp_o | output | 1 | Jump select for the next-PC logic |
| ext_sign_o | output | 1 | 1: sign-extend the immediate; 0: zero-extend |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |

## Verification
The hardest cases to reach are the near misses: a register-type word whose function field is close to add or subtract, and a non-register operation that carries an add-like function field. Uniform random stimulus almost never produces either. The stimulus therefore draws most operation fields from the six legal codes and, for register type, picks add or subtract function codes about half of the time. Directed vectors cover function codes one bit away from add, a branch operation paired with 100000, and operation fields one bit away from load and store.

// File: rtl/scd_pkg.sv
package scd_pkg;

  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALU_W   = 2;
  localparam int N_TERMS = 7;

  typedef enum int unsigned {
    T_ADD = 0, T_SUB = 1, T_ORI = 2, T_LD = 3, T_ST = 4, T_BEQ = 5, T_JMP = 6
  } term_e;

  typedef logic [ALU_W-1:0] alu_op_t;
  localparam alu_op_t ALU_ADD = 2'b00;
  localparam alu_op_t ALU_SUB = 2'b01;
  localparam alu_op_t ALU_OR  = 2'b10;

  // Packed so that each member sits on a fixed OR-plane line index.
  typedef struct packed {
    logic    dst_rd;     // line 9
    logic    alu_b_imm;  // line 8
    logic    wb_mem;     // line 7
    logic    rf_we;      // line 6
    logic    dm_we;      // line 5
    logic    br_sel;     // line 4
    logic    jmp;        // line 3
    logic    ext_sign;   // line 2
    alu_op_t alu_op;     // lines 1..0
  } ctl_t;

  localparam int N_LINES = $bits(ctl_t);
  localparam int L_ALU0 = 0, L_ALU1 = 1, L_EXT = 2, L_JMP = 3, L_BR = 4,
                 L_DMWE = 5, L_RFWE = 6, L_WB = 7, L_BIMM = 8, L_DST = 9;

  function automatic logic [OP_W-1:0] term_op(input int k);
    case (k)
      T_ADD, T_SUB: term_op = 6'b000000;
      T_ORI:        term_op = 6'b001101;
      T_LD:         term_op = 6'b100011;
      T_ST:         term_op = 6'b101011;
      T_BEQ:        term_op = 6'b000100;
      default:      term_op = 6'b000010;
    endcase
  endfunction

  function automatic logic term_uses_fn(input int k);
    term_uses_fn = (k == T_ADD) || (k == T_SUB);
  endfunction

  function automatic logic [FN_W-1:0] term_fn(input int k);
    term_fn = (k == T_SUB) ? 6'b100010 : 6'b100000;
  endfunction

  // Which product terms feed each OR-plane line; don't-cares are left out.
  function automatic logic [N_TERMS-1:0] line_mask(input int line);
    logic [N_TERMS-1:0] m;
    m = '0;
    case (line)
      L_DST:  begin m[T_ADD] = 1'b1; m[T_SUB] = 1'b1; end
      L_BIMM: begin m[T_ORI] = 1'b1; m[T_LD] = 1'b1; m[T_ST] = 1'b1; end
      L_WB:   m[T_LD] = 1'b1;
      L_RFWE: begin m[T_ADD] = 1'b1; m[T_SUB] = 1'b1; m[T_ORI] = 1'b1; m[T_LD] = 1'b1; end
      L_DMWE: m[T_ST] = 1'b1;
      L_BR:   m[T_BEQ] = 1'b1;
      L_JMP:  m[T_JMP] = 1'b1;
      L_EXT:  begin m[T_LD] = 1'b1; m[T_ST] = 1'b1; end
      L_ALU0: begin m[T_SUB] = 1'b1; m[T_BEQ] = 1'b1; end
      L_ALU1: m[T_ORI] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/scd_and_plane.sv
module scd_and_plane
  import scd_pkg::*;
#(
  parameter int P_OP_W    = OP_W,
  parameter int P_FN_W    = FN_W,
  parameter int P_N_TERMS = N_TERMS
) (
  input  logic [P_OP_W-1:0]    op_i,
  input  logic [P_FN_W-1:0]    fn_i,
  output logic [P_N_TERMS-1:0] hit_o
);

  for (genvar k = 0; k < P_N_TERMS; k++) begin : g_term
    localparam logic [P_OP_W-1:0] OPK  = term_op(k);
    localparam logic [P_FN_W-1:0] FNK  = term_fn(k);
    localparam logic              USEF = term_uses_fn(k);
    assign hit_o[k] = (op_i == OPK) && (!USEF || (fn_i == FNK));
  end

  // At most one instruction may be recognised at a time (R1).
  always_comb begin
    p_single_term_r1: assert ($onehot0(hit_o))
      else $error("more than one decode term active");
  end

endmodule

// File: rtl/scd_or_plane.sv
module scd_or_plane
  import scd_pkg::*;
#(
  parameter int P_N_TERMS = N_TERMS,
  parameter int P_N_LINES = N_LINES
) (
  input  logic [P_N_TERMS-1:0] hit_i,
  output logic [P_N_LINES-1:0] line_o
);

  for (genvar l = 0; l < P_N_LINES; l++) begin : g_line
    localparam logic [P_N_TERMS-1:0] MASK = line_mask(l);
    assign line_o[l] = |(hit_i & MASK);
  end

endmodule

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode
  import scd_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       dst_rd_o,
  output logic       alu_b_imm_o,
  output logic       wb_mem_o,
  output logic       rf_we_o,
  output logic       dm_we_o,
  output logic       br_sel_o,
  output logic       jmp_o,
  output logic       ext_sign_o,
  output logic [1:0] alu_op_o
);

  logic [N_TERMS-1:0] hit;
  logic [N_LINES-1:0] lines;
  ctl_t               ctl;

  scd_and_plane #(.P_OP_W(OP_W), .P_FN_W(FN_W), .P_N_TERMS(N_TERMS)) u_and (
    .op_i (op_i),
    .fn_i (fn_i),
    .hit_o(hit)
  );

  scd_or_plane #(.P_N_TERMS(N_TERMS), .P_N_LINES(N_LINES)) u_or (
    .hit_i (hit),
    .line_o(lines)
  );

  assign ctl         = ctl_t'(lines);
  assign dst_rd_o    = ctl.dst_rd;
  assign alu_b_imm_o = ctl.alu_b_imm;
  assign wb_mem_o    = ctl.wb_mem;
  assign rf_we_o     = ctl.rf_we;
  assign dm_we_o     = ctl.dm_we;
  assign br_sel_o    = ctl.br_sel;
  assign jmp_o       = ctl.jmp;
  assign ext_sign_o  = ctl.ext_sign;
  assign alu_op_o    = ctl.alu_op;

  always_comb begin
    // R9: no recognised term leaves every output low.
    p_unknown_quiet_r9: assert ((hit != '0) || (lines == '0))
      else $error("unrecognised word drove a control line");
    // R5/R6: a store never writes the register file.
    p_store_no_rf_r5: assert (!(dm_we_o && rf_we_o))
      else $error("store also wrote the register file");
    // R7: branch and jump selects are exclusive.
    p_br_jmp_excl_r7: assert (!(br_sel_o && jmp_o))
      else $error("branch and jump both selected");
    // R2: a branch compares by subtracting.
    p_branch_sub_r2: assert (!br_sel_o || (alu_op_o == ALU_SUB))
      else $error("branch without subtract");
    // R8: sign extension only where the immediate is used.
    p_ext_imm_r8: assert (!ext_sign_o || alu_b_imm_o)
      else $error("sign extension without immediate operand");
    // R2: the ALU code never takes the unused value 11.
    p_alu_code_r2: assert (alu_op_o != 2'b11)
      else $error("illegal ALU code");
  end

endmodule

// File: tb/sc_ctrl_decode_bench.sv
module sc_ctrl_decode_bench;

  localparam time TCLK = 20ns;
  localparam int  MAX_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n;
  always #(TCLK/2) clk = ~clk;

  logic [5:0] op, fn;
  logic dst, bimm, wb, rfwe, dmwe, br, jmp, ext;
  logic [1:0] aluop;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  sc_ctrl_decode u_sc_ctrl_decode (
    .op_i(op), .fn_i(fn), .dst_rd_o(dst), .alu_b_imm_o(bimm), .wb_mem_o(wb),
    .rf_we_o(rfwe), .dm_we_o(dmwe), .br_sel_o(br), .jmp_o(jmp),
    .ext_sign_o(ext), .alu_op_o(aluop)
  );

  // Expected outputs, packed {dst,bimm,wb,rfwe,dmwe,br,jmp,ext,alu[1:0]}.
  function automatic logic [9:0] expect_ctl(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'b000000: begin
        if (f == 6'b100000)      expect_ctl = 10'b1_0_0_1_0_0_0_0_00; // add
        else if (f == 6'b100010) expect_ctl = 10'b1_0_0_1_0_0_0_0_01; // sub
        else                     expect_ctl = '0;                    // R9
      end
      6'b001101: expect_ctl = 10'b0_1_0_1_0_0_0_0_10; // ori
      6'b100011: expect_ctl = 10'b0_1_1_1_0_0_0_1_00; // load
      6'b101011: expect_ctl = 10'b0_1_0_0_1_0_0_1_00; // store
      6'b000100: expect_ctl = 10'b0_0_0_0_0_1_0_0_01; // beq
      6'b000010: expect_ctl = 10'b0_0_0_0_0_0_1_0_00; // jump
      default:   expect_ctl = '0;                     // R9
    endcase
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, op, fn, act, exp_v);
    end
  endtask

  task automatic apply(input logic [5:0] o, input logic [5:0] f);
    logic [9:0] e;
    @(negedge clk);
    op = o; fn = f;
    #(TCLK/4);
    e = expect_ctl(o, f);
    chk("R3 dst_rd",    {1'b0, dst},  {1'b0, e[9]});
    chk("R4 alu_b_imm", {1'b0, bimm}, {1'b0, e[8]});
    chk("R5 wb_mem",    {1'b0, wb},   {1'b0, e[7]});
    chk("R6 rf_we",     {1'b0, rfwe}, {1'b0, e[6]});
    chk("R5 dm_we",     {1'b0, dmwe}, {1'b0, e[5]});
    chk("R7 br_sel",    {1'b0, br},   {1'b0, e[4]});
    chk("R7 jmp",       {1'b0, jmp},  {1'b0, e[3]});
    chk("R8 ext_sign",  {1'b0, ext},  {1'b0, e[2]});
    chk("R2 alu_op",    aluop,        e[1:0]);
    if (e == '0) chk("R9 R10 all-zero", {1'b0, |{dst,bimm,wb,rfwe,dmwe,br,jmp,ext,aluop}}, 2'b00);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > MAX_CYC) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  localparam logic [5:0] LEGAL_OPS [6] = '{6'b000000, 6'b001101, 6'b100011,
                                           6'b101011, 6'b000100, 6'b000010};

  initial begin : stim
    logic [5:0] ro, rf;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    op = '0; fn = 6'b111111;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Reset-time state: register word with unused function field is quiet (R9).
    apply(6'b000000, 6'b111111);
    // R1: each instruction, directed.
    apply(6'b000000, 6'b100000);
    apply(6'b000000, 6'b100010);
    apply(6'b001101, 6'b010101);
    apply(6'b100011, 6'b000000);
    apply(6'b101011, 6'b111111);
    apply(6'b000100, 6'b100000); // R1 function field ignored for beq
    apply(6'b000010, 6'b100010);
    // R9 near misses.
    apply(6'b000000, 6'b100001);
    apply(6'b000000, 6'b100100);
    apply(6'b100001, 6'b100000);
    apply(6'b101111, 6'b000000);
    apply(6'b111111, 6'b111111);
    // Constrained random.
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) != 0) ro = LEGAL_OPS[$urandom_range(5)];
      else                        ro = 6'($urandom);
      if ((ro == 6'b000000) && $urandom_range(1) == 1)
        rf = $urandom_range(1) ? 6'b100010 : 6'b100000;
      else
        rf = 6'($urandom);
      apply(ro, rf);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule